// File: doc/BRIEF.md
# Bit-clocked timestamp timer with network sync

This block keeps a 16-bit time base for stamping bus messages. The count moves forward by one for each bit time that the bus controller reports while a frame is on the wire. It therefore measures time in bit periods rather than in system clock cycles. Between frames the count holds its value.

A node can align its time base with other nodes on the network. When sync mode is on and a message is stored into the designated sync buffer, the count returns to zero. The sync buffer is slot 0 in normal operation. When the receive FIFO is enabled, the sync buffer is slot 8. A CPU can read the count at any time from the output and can load a new value through a one-cycle write strobe.

Top module: `bitstamp_timer`

## Requirements
- R1: While `rst_n` is low, `stamp` reads 0x0000 on the clock edge that follows.
- R2: `stamp` goes up by one on a clock edge only when `bit_tick` and `frame_busy` are both high in that cycle. If either is low, and there is no write or sync, `stamp` keeps its value.
- R3: An increment from 0xFFFF gives 0x0000.
- R4: When `cpu_wr` is high, `stamp` takes the value of `cpu_wdata` on the next edge.
- R5: If a CPU write and an increment happen in the same cycle, the written value wins and is not incremented.
- R6: With `sync_on` high and `fifo_on` low, a `rx_done` pulse with `rx_slot` = 0 makes `stamp` 0x0000 on the next edge. This sync reset wins over a CPU write and over an increment in the same cycle.
- R7: With `fifo_on` high, the sync trigger is `rx_slot` = 8, and a receive into slot 0 does not reset the count.
- R8: While `sync_on` is low, a receive into the sync slot leaves `stamp` unchanged.
- R9: While `rx_done` is low, the value on `rx_slot` has no effect on `stamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe, once per bus bit time |
| frame_busy | input | 1 | High while a frame is being sent or received |
| rx_done | input | 1 | One-cycle pulse: a message has been stored |
| rx_slot | input | 6 | Index of the buffer that received the message |
| sync_on | input | 1 | Enables the sync-on-receive reset |
| fifo_on | input | 1 | Receive FIFO enabled; moves the sync slot from 0 to 8 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | Value the CPU loads |
| stamp | output | 16 | Current timer value |

## Verification
The bench drives the count to 0xFFFF and then increments it, so a counter that saturates or that spills into a wider register fails. It applies a sync receive, a CPU write and a bit tick in one cycle. A design with the priorities swapped would show the written value or the written value plus one where zero is expected. It sends receives to slot 0 and to slot 8 with the FIFO flag both off and on. A design that ignores the FIFO flag would clear the count on the wrong slot. Receives with sync disabled, and slot values presented without `rx_done`, show whether the count is cleared when it should not be.

// File: rtl/bst_pkg.sv
// Shared types for the bit-clocked timestamp timer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package bst_pkg;

    // Source of the next timer value, in rising priority order.
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_STEP  = 2'd1,
        UPD_LOAD  = 2'd2,
        UPD_CLEAR = 2'd3
    } upd_e;

endpackage

// File: rtl/bst_sync_match.sv
// Detects a receive into the sync buffer.
// The target slot is BASE_SLOT, or FIFO_SLOT when the FIFO is enabled.
// Assumes: rx_done is a one-cycle pulse and rx_slot is valid with it.
module bst_sync_match #(
    parameter int SLOT_W    = 6,
    parameter int BASE_SLOT = 0,
    parameter int FIFO_SLOT = 8
) (
    input  logic              rx_done,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic              sync_on,
    input  logic              fifo_on,
    output logic              sync_hit
);

    localparam logic [SLOT_W-1:0] TGT_BASE = SLOT_W'(BASE_SLOT);
    localparam logic [SLOT_W-1:0] TGT_FIFO = SLOT_W'(FIFO_SLOT);

    logic [SLOT_W-1:0] target;

    // Pick the trigger slot for the current buffer mode.
    always_comb begin
        target = fifo_on ? TGT_FIFO : TGT_BASE;
    end

    // A hit needs sync enabled, a receive pulse and a matching slot.
    always_comb begin
        sync_hit = sync_on && rx_done && (rx_slot == target);
    end

endmodule

// File: rtl/bst_update_arb.sv
// Chooses where the next timer value comes from.
// Priority: sync clear, then CPU load, then bit step, then hold.
// Assumes: all inputs are synchronous to the timer clock.
module bst_update_arb
    import bst_pkg::*;
(
    input  logic sync_hit,
    input  logic cpu_wr,
    input  logic bit_tick,
    input  logic frame_busy,
    output upd_e upd
);

    // Fixed-priority selection of the update source.
    always_comb begin
        if (sync_hit) begin
            upd = UPD_CLEAR;
        end else if (cpu_wr) begin
            upd = UPD_LOAD;
        end else if (bit_tick && frame_busy) begin
            upd = UPD_STEP;
        end else begin
            upd = UPD_HOLD;
        end
    end

endmodule

// File: rtl/bst_counter.sv
// Timer register of CNT_W bits that wraps modulo 2**CNT_W.
// Assumes: upd is already resolved by priority; synchronous active-low reset.
module bst_counter
    import bst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_e             upd,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    // Register the next count according to the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else begin
            case (upd)
                UPD_CLEAR: count <= ZERO;
                UPD_LOAD:  count <= wdata;
                UPD_STEP:  count <= count + ONE;
                default:   count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bitstamp_timer.sv
// Top of the bit-clocked timestamp timer.
// It counts bus bit times during frames, takes CPU loads, and clears on a
// receive into the sync slot when sync mode is on.
// Assumes: bit_tick, rx_done and cpu_wr are single-cycle strobes in clk.
module bitstamp_timer
    import bst_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SLOT_W    = 6,
    parameter int BASE_SLOT = 0,
    parameter int FIFO_SLOT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_busy,
    input  logic              rx_done,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic              sync_on,
    input  logic              fifo_on,
    input  logic              cpu_wr,
    input  logic [CNT_W-1:0]  cpu_wdata,
    output logic [CNT_W-1:0]  stamp
);

    logic sync_hit;
    upd_e upd;

    bst_sync_match #(
        .SLOT_W   (SLOT_W),
        .BASE_SLOT(BASE_SLOT),
        .FIFO_SLOT(FIFO_SLOT)
    ) u_match (
        .rx_done (rx_done),
        .rx_slot (rx_slot),
        .sync_on (sync_on),
        .fifo_on (fifo_on),
        .sync_hit(sync_hit)
    );

    bst_update_arb u_arb (
        .sync_hit  (sync_hit),
        .cpu_wr    (cpu_wr),
        .bit_tick  (bit_tick),
        .frame_busy(frame_busy),
        .upd       (upd)
    );

    bst_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (upd),
        .wdata(cpu_wdata),
        .count(stamp)
    );

endmodule

// File: rtl/bitstamp_timer_chk.sv
// Property checker for bitstamp_timer, attached with bind below.
// Assumes: the default slot parameters (sync slot 0, FIFO sync slot 8).
module bitstamp_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              frame_busy,
    input logic              rx_done,
    input logic [SLOT_W-1:0] rx_slot,
    input logic              sync_on,
    input logic              fifo_on,
    input logic              cpu_wr,
    input logic [CNT_W-1:0]  cpu_wdata,
    input logic              sync_hit,
    input logic [CNT_W-1:0]  stamp
);

    // R1: reset forces zero
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> stamp == '0);

    // R2 and R3: a step adds one modulo 2**CNT_W
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_busy && !cpu_wr && !sync_hit)
        |=> stamp == CNT_W'($past(stamp) + CNT_W'(1)));

    // R2: no step, no write, no sync means hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bit_tick && frame_busy) && !cpu_wr && !sync_hit)
        |=> $stable(stamp));

    // R4 and R5: a write without sync loads the data
    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !sync_hit) |=> stamp == $past(cpu_wdata));

    // R6: a sync hit clears the timer
    p_sync_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> stamp == '0);

    // R7: in FIFO mode slot 0 does not trigger
    p_fifo_slot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && rx_slot == '0) |-> !sync_hit);

    // R8: sync disabled never triggers
    p_sync_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |-> !sync_hit);

    // R9: no receive pulse never triggers
    p_no_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> !sync_hit);

endmodule

bind bitstamp_timer bitstamp_timer_chk #(
    .CNT_W (CNT_W),
    .SLOT_W(SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .frame_busy(frame_busy),
    .rx_done   (rx_done),
    .rx_slot   (rx_slot),
    .sync_on   (sync_on),
    .fifo_on   (fifo_on),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .sync_hit  (sync_hit),
    .stamp     (stamp)
);

// File: tb/test_bitstamp_timer.sv
// Self-checking bench: directed corner cases plus seeded random traffic.
module test_bitstamp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        frame_busy = 1'b0;
    logic        rx_done = 1'b0;
    logic [5:0]  rx_slot = '0;
    logic        sync_on = 1'b0;
    logic        fifo_on = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] stamp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model = '0;

    always #4 clk = ~clk;

    bitstamp_timer i_bitstamp_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_busy(frame_busy),
        .rx_done(rx_done), .rx_slot(rx_slot), .sync_on(sync_on),
        .fifo_on(fifo_on), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .stamp(stamp)
    );

    // Reference next value from the requirements.
    function automatic logic [15:0] next_val(logic [15:0] cur, logic tk, logic bz,
            logic rd, logic [5:0] sl, logic so, logic fo, logic wr, logic [15:0] wd);
        logic [5:0] tgt;
        tgt = fo ? 6'd8 : 6'd0;
        if (so && rd && sl == tgt) return 16'h0000;
        if (wr) return wd;
        if (tk && bz) return cur + 16'h0001;
        return cur;
    endfunction

    // Requirement that governs a given input combination.
    function automatic string tag_of(logic [15:0] cur, logic tk, logic bz,
            logic rd, logic [5:0] sl, logic so, logic fo, logic wr);
        if (so && rd && sl == (fo ? 6'd8 : 6'd0)) return fo ? "R7" : "R6";
        if (wr) return (tk && bz) ? "R5" : "R4";
        if (tk && bz) return (cur == 16'hFFFF) ? "R3" : "R2";
        if (rd && !so) return "R8";
        if (rd && fo && sl == 6'd0) return "R7";
        if (!rd) return "R9";
        return "R2";
    endfunction

    task automatic check(logic [15:0] exp, string tag);
        checks++;
        if (stamp !== exp) begin
            fails++;
            $display("FAIL %s: stamp=%h expected=%h", tag, stamp, exp);
        end
    endtask

    // Drive one cycle, update the model, then compare after the edge.
    task automatic step(logic tk, logic bz, logic rd, logic [5:0] sl, logic so,
            logic fo, logic wr, logic [15:0] wd, string tag);
        bit_tick = tk; frame_busy = bz; rx_done = rd; rx_slot = sl;
        sync_on = so; fifo_on = fo; cpu_wr = wr; cpu_wdata = wd;
        model = next_val(model, tk, bz, rd, sl, so, fo, wr, wd);
        @(posedge clk);
        @(negedge clk);
        check(model, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: stamp=%h expected=run end", stamp);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset with activity on the inputs
        rst_n = 1'b0; bit_tick = 1'b1; frame_busy = 1'b1; cpu_wr = 1'b1; cpu_wdata = 16'hBEEF;
        repeat (3) @(negedge clk);
        model = '0;
        check(16'h0000, "R1");
        rst_n = 1'b1;
        // R2: ticks inside a frame count; ticks or busy alone hold
        step(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R2");
        // R4 then R3: load 0xFFFF and wrap
        step(0, 0, 0, 0, 0, 0, 1, 16'hFFFF, "R4");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R5: write beats a step
        step(1, 1, 0, 0, 0, 0, 1, 16'h1234, "R5");
        // R6: sync beats write and step
        step(1, 1, 1, 6'd0, 1, 0, 1, 16'h5555, "R6");
        // R7: FIFO mode, slot 0 ignored, slot 8 clears
        step(0, 0, 0, 0, 0, 0, 1, 16'h0ABC, "R4");
        step(0, 0, 1, 6'd0, 1, 1, 0, 0, "R7");
        step(0, 0, 1, 6'd8, 1, 1, 0, 0, "R7");
        // R6 side: slot 8 without FIFO does nothing
        step(0, 0, 0, 0, 0, 0, 1, 16'h0777, "R4");
        step(0, 0, 1, 6'd8, 1, 0, 0, 0, "R6");
        // R8: sync off, receive into slot 0 ignored
        step(0, 0, 1, 6'd0, 0, 0, 0, 0, "R8");
        // R9: slot 0 without rx_done ignored
        step(0, 0, 0, 6'd0, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 6'd8, 1, 1, 0, 0, "R9");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic tk, bz, rd, so, fo, wr;
            logic [5:0] sl;
            logic [15:0] wd;
            string tg;
            tk = ($urandom % 2) == 0;
            bz = ($urandom % 4) != 0;
            rd = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: sl = 6'd0;
                1: sl = 6'd8;
                default: sl = 6'($urandom);
            endcase
            so = ($urandom % 2) == 0;
            fo = ($urandom % 2) == 0;
            wr = ($urandom % 16) == 0;
            wd = (($urandom % 4) == 0) ? 16'hFFFE : 16'($urandom);
            tg = tag_of(model, tk, bz, rd, sl, so, fo, wr);
            step(tk, bz, rd, sl, so, fo, wr, wd, tg);
        end
        finish_run();
    end

endmodule